// File: doc/BRIEF.md
# Regulator Start-up and Soft-start Sequencer

This block sequences the digital side of a regulator's power-up. Leaving reset, it first asks a storage stub whether user settings were saved and waits for that to finish, then asks a pin-sampling stub to read the configuration straps. Only when both have completed does it raise `ready`. Before that point the `enable` input has no effect, and this holds even when `enable` is already high at reset.

Once ready, a rising `enable` starts a delay timer. The timer counts in ticks of `TICK_DIV` clocks each. The delay it uses is the larger of the configured value and a fixed floor of `MIN_DELAY_TICKS` ticks. When the delay expires, the block divides the target code by the ramp length to get an integer step and a remainder. It then raises the reference code once per tick, spreading the remainder with an error accumulator so that the code arrives exactly at the target on the last tick of the ramp. Dropping `enable` at any point after initialisation returns the code to zero and the block to ready-idle.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `nvmCheckStart` is high, `pinSampleStart` is low, `ready` is low and `refCode` is 0. `pinSampleStart` stays low until `nvmCheckDone` has been seen.
- R2: After `nvmCheckDone`, `nvmCheckStart` falls and `pinSampleStart` rises. The block stalls with `ready` low until `pinSampleDone` arrives.
- R3: `ready` rises in the cycle after `pinSampleDone` and never falls until reset. While `ready` is low, `refCode` is 0 and `ramping` and `done` are low, whatever `enable` does.
- R4: When `cfgDelay` is below `MIN_DELAY_TICKS`, the ramp starts no earlier than `MIN_DELAY_TICKS` ticks after enable is accepted.
- R5: When `cfgDelay` is at or above `MIN_DELAY_TICKS`, the ramp starts `cfgDelay` ticks after enable is accepted. The allowance for the divide is at most `CW` + `TICK_DIV` + 4 clocks.
- R6: While `ramping` is high, `refCode` never decreases and never exceeds `targetCode`.
- R7: A ramp with nonzero `cfgRamp` lasts `cfgRamp` ticks (one tick is `TICK_DIV` clocks). It ends with `done` high and `refCode` equal to `targetCode`.
- R8: Deasserting `enable` after initialisation clears `refCode` to 0 in the next cycle and drops `ramping` and `done`, while `ready` stays high.
- R9: With `cfgRamp` equal to 0, the code jumps to `targetCode` and `done` rises as soon as the delay expires, with no ramp phase.
- R10: With `enable` held high from reset, the ramp begins only after initialisation and the full delay have both elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Output enable request |
| cfgDelay | input | DW | Configured start delay in ticks |
| cfgRamp | input | DW | Configured ramp length in ticks |
| targetCode | input | CW | Final reference code |
| nvmCheckStart | output | 1 | Request to storage-check stub, held until done |
| nvmCheckDone | input | 1 | Storage check and load finished (pulse) |
| pinSampleStart | output | 1 | Request to pin-sample stub, held until done |
| pinSampleDone | input | 1 | Pin sampling finished (pulse) |
| refCode | output | CW | Digital output-voltage reference code |
| ready | output | 1 | Initialisation complete |
| ramping | output | 1 | Ramp in progress |
| done | output | 1 | Reference has reached the target |

## Verification
The assertions run on every cycle and cover the orderings and invariants. They check that pin sampling never precedes the storage check, that `ready` never falls, and that the outputs stay quiet before `ready`. They also check that the code never falls or overshoots while ramping, that the code is zero right after `enable` drops, that `done` implies the target, and that a ramp never starts before the delay floor has elapsed. Only the bench scenarios can show the actual durations. These are a configured delay longer than the floor, the ramp length in ticks, and the zero-length ramp. The scenarios also exercise an enable held from reset, and an abort in mid-ramp followed by clean restarts.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [2:0] {
    ST_NVM, ST_PIN, ST_IDLE, ST_DELAY, ST_DIV, ST_RAMP, ST_DONE
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrTimer;
    logic divStart;
    logic rampStep;
    logic zeroCode;
    logic loadTarget;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic delayDone;
    logic divDone;
    logic rampLast;
  } seqStatus_t;

endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import softstart_pkg::*;
#(
  parameter int TICK_DIV        = 125,
  parameter int MIN_DELAY_TICKS = 2000,
  parameter int DW              = 16,
  parameter int CW              = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] cfgDelay,
  input  logic [DW-1:0] cfgRamp,
  input  logic [CW-1:0] targetCode,
  input  seqStrobe_t    strb,
  output seqStatus_t    stat,
  output logic [CW-1:0] refCode
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int BW = $clog2(CW + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [DW-1:0] MIN_DLY  = DW'(MIN_DELAY_TICKS);

  logic [PW-1:0] preCnt;
  logic [DW-1:0] tickCnt;
  logic          tick;
  logic [DW-1:0] effDelay;

  logic [CW-1:0] quo;
  logic [DW-1:0] remR;
  logic [BW-1:0] bitCnt;
  logic          divBusy;
  logic [DW:0]   trial, diffW;

  logic [DW:0]   errAcc, errSum;
  logic          carry;
  logic [CW:0]   nextCode;

  assign tick     = !strb.clrTimer && (preCnt == PRE_LAST);
  assign effDelay = (cfgDelay < MIN_DLY) ? MIN_DLY : cfgDelay;

  assign stat.delayDone = tick && (tickCnt == effDelay - 1'b1);
  assign stat.rampLast  = tick && (tickCnt == cfgRamp - 1'b1);
  assign stat.divDone   = divBusy && (bitCnt == BW'(1));

  // tick prescaler and tick counter, restarted together
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) tickCnt <= tickCnt + 1'b1;
    end
  end

  // restoring divider: step = target / ramp, remR = target % ramp
  assign trial = {remR, quo[CW-1]};
  assign diffW = trial - {1'b0, cfgRamp};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quo     <= '0;
      remR    <= '0;
      bitCnt  <= '0;
      divBusy <= 1'b0;
    end else if (strb.divStart) begin
      quo     <= targetCode;
      remR    <= '0;
      bitCnt  <= BW'(CW);
      divBusy <= 1'b1;
    end else if (divBusy) begin
      if (trial >= {1'b0, cfgRamp}) begin
        remR <= diffW[DW-1:0];
        quo  <= {quo[CW-2:0], 1'b1};
      end else begin
        remR <= trial[DW-1:0];
        quo  <= {quo[CW-2:0], 1'b0};
      end
      bitCnt <= bitCnt - 1'b1;
      if (bitCnt == BW'(1)) divBusy <= 1'b0;
    end
  end

  // ramp: add step each tick, plus one when the remainder accumulator wraps
  assign errSum   = errAcc + {1'b0, remR};
  assign carry    = errSum >= {1'b0, cfgRamp};
  assign nextCode = {1'b0, refCode} + {1'b0, quo} + (CW+1)'(carry);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) begin
      errAcc <= '0;
    end else if (strb.rampStep && tick) begin
      errAcc <= carry ? errSum - {1'b0, cfgRamp} : errSum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.zeroCode) begin
      refCode <= '0;
    end else if (strb.loadTarget) begin
      refCode <= targetCode;
    end else if (strb.rampStep && tick) begin
      if (stat.rampLast || nextCode > {1'b0, targetCode}) refCode <= targetCode;
      else refCode <= nextCode[CW-1:0];
    end
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import softstart_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [DW-1:0] cfgRamp,
  input  logic          nvmCheckDone,
  input  logic          pinSampleDone,
  input  seqStatus_t    stat,
  output seqStrobe_t    strb,
  output logic          nvmCheckStart,
  output logic          pinSampleStart,
  output logic          ready,
  output logic          ramping,
  output logic          done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NVM;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_NVM:  if (nvmCheckDone)  stateNext = ST_PIN;
      ST_PIN:  if (pinSampleDone) stateNext = ST_IDLE;
      ST_IDLE: begin
        strb.zeroCode = 1'b1;
        if (enable) begin
          stateNext     = ST_DELAY;
          strb.clrTimer = 1'b1;
        end
      end
      default: begin
        if (!enable) begin
          stateNext     = ST_IDLE;
          strb.zeroCode = 1'b1;
        end else begin
          case (state)
            ST_DELAY: if (stat.delayDone) begin
              if (cfgRamp == '0) begin
                stateNext       = ST_DONE;
                strb.loadTarget = 1'b1;
              end else begin
                stateNext     = ST_DIV;
                strb.divStart = 1'b1;
              end
            end
            ST_DIV: if (stat.divDone) begin
              stateNext     = ST_RAMP;
              strb.clrTimer = 1'b1;
            end
            ST_RAMP: begin
              strb.rampStep = 1'b1;
              if (stat.rampLast) stateNext = ST_DONE;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  assign nvmCheckStart  = (state == ST_NVM);
  assign pinSampleStart = (state == ST_PIN);
  assign ready          = (state != ST_NVM) && (state != ST_PIN);
  assign ramping        = (state == ST_RAMP);
  assign done           = (state == ST_DONE);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int TICK_DIV        = 125,
  parameter int MIN_DELAY_TICKS = 2000,
  parameter int DW              = 16,
  parameter int CW              = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [DW-1:0] cfgDelay,
  input  logic [DW-1:0] cfgRamp,
  input  logic [CW-1:0] targetCode,
  output logic          nvmCheckStart,
  input  logic          nvmCheckDone,
  output logic          pinSampleStart,
  input  logic          pinSampleDone,
  output logic [CW-1:0] refCode,
  output logic          ready,
  output logic          ramping,
  output logic          done
);
  seqStrobe_t strb;
  seqStatus_t stat;

  seqControl #(.DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgRamp(cfgRamp),
    .nvmCheckDone(nvmCheckDone), .pinSampleDone(pinSampleDone),
    .stat(stat), .strb(strb),
    .nvmCheckStart(nvmCheckStart), .pinSampleStart(pinSampleStart),
    .ready(ready), .ramping(ramping), .done(done)
  );

  seqDatapath #(
    .TICK_DIV(TICK_DIV), .MIN_DELAY_TICKS(MIN_DELAY_TICKS), .DW(DW), .CW(CW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgDelay(cfgDelay), .cfgRamp(cfgRamp),
    .targetCode(targetCode), .strb(strb), .stat(stat), .refCode(refCode)
  );
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int TICK_DIV        = 125,
  parameter int MIN_DELAY_TICKS = 2000,
  parameter int DW              = 16,
  parameter int CW              = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic [CW-1:0] targetCode,
  input logic          nvmCheckStart,
  input logic          nvmCheckDone,
  input logic          pinSampleStart,
  input logic [CW-1:0] refCode,
  input logic          ready,
  input logic          ramping,
  input logic          done
);
  localparam int FLOOR_CYC = MIN_DELAY_TICKS * TICK_DIV;

  logic nvmSeen;
  int   enCyc;

  always_ff @(posedge clk) begin
    if (!rstN) nvmSeen <= 1'b0;
    else if (nvmCheckStart && nvmCheckDone) nvmSeen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable || !ready) enCyc <= 0;
    else if (enCyc < FLOOR_CYC) enCyc <= enCyc + 1;
  end

  // R1
  pin_after_nvm_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinSampleStart |-> nvmSeen && !nvmCheckStart);

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R3
  quiet_before_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (refCode == '0) && !ramping && !done);

  // R4
  delay_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramping) |-> enCyc >= FLOOR_CYC);

  // R6
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramping && $past(ramping) |-> refCode >= $past(refCode));

  // R6
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramping |-> refCode <= targetCode);

  // R7
  done_at_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> refCode == targetCode);

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && !enable |=> (refCode == '0) && !ramping && !done);
endmodule

bind softstart_seq softstart_seq_chk #(
  .TICK_DIV(TICK_DIV), .MIN_DELAY_TICKS(MIN_DELAY_TICKS), .DW(DW), .CW(CW)
) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .targetCode(targetCode),
  .nvmCheckStart(nvmCheckStart), .nvmCheckDone(nvmCheckDone),
  .pinSampleStart(pinSampleStart), .refCode(refCode), .ready(ready),
  .ramping(ramping), .done(done)
);

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
  localparam int T   = 4;
  localparam int MIN = 10;
  localparam int DW  = 12;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rstN, enable, nvmCheckDone, pinSampleDone;
  logic [DW-1:0] cfgDelay, cfgRamp;
  logic [CW-1:0] targetCode, refCode;
  logic nvmCheckStart, pinSampleStart, ready, ramping, done;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0, monoBad = 0;
  int expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  softstart_seq #(.TICK_DIV(T), .MIN_DELAY_TICKS(MIN), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgDelay(cfgDelay),
    .cfgRamp(cfgRamp), .targetCode(targetCode),
    .nvmCheckStart(nvmCheckStart), .nvmCheckDone(nvmCheckDone),
    .pinSampleStart(pinSampleStart), .pinSampleDone(pinSampleDone),
    .refCode(refCode), .ready(ready), .ramping(ramping), .done(done)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // which: 0 ramping, 1 done, 2 ready; returns negedges waited
  task automatic waitFor(int which, output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if ((which == 0 && ramping) || (which == 1 && done) || (which == 2 && ready))
        break;
    end
  endtask

  // driver side of scoreboard: expected final code of next completed run
  task automatic expectCode(int code);
    expQ.push_back(code);
  endtask

  // monitor: compare code at each done rise; track monotonic ramp (R6)
  initial begin
    logic doneQ = 1'b0, rampQ = 1'b0;
    int prev = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (done && !doneQ) begin
          if (expQ.size() == 0) check("R7 unexpected done", 1, 0);
          else check("R7 final code", int'(refCode), expQ.pop_front());
        end
        if (ramping && rampQ && int'(refCode) < prev) monoBad = 1;
        if (ramping && int'(refCode) > int'(targetCode)) monoBad = 1;
      end
      doneQ = done; rampQ = ramping; prev = int'(refCode);
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 0; enable = 1; cfgDelay = 3; cfgRamp = 7; targetCode = 500;
    nvmCheckDone = 0; pinSampleDone = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 nvmCheckStart", nvmCheckStart, 1);
    check("R1 pinSampleStart", pinSampleStart, 0);
    check("R1 ready", ready, 0);
    check("R1 refCode", refCode, 0);
    repeat (20) @(negedge clk);
    check("R1 pin waits for nvm", pinSampleStart, 0);
    check("R3 enable ignored before ready", ramping, 0);
    nvmCheckDone = 1; @(negedge clk); nvmCheckDone = 0;
    check("R2 pinSampleStart", pinSampleStart, 1);
    check("R2 nvmCheckStart drop", nvmCheckStart, 0);
    repeat (15) @(negedge clk);
    check("R2 stall until pin done", ready, 0);
    pinSampleDone = 1; @(negedge clk); pinSampleDone = 0;
    check("R3 ready after init", ready, 1);

    // R10 + R4: enable held from reset, short delay raised to floor
    expectCode(500);
    waitFor(0, n);
    checkRange("R10 R4 floor delay", n, MIN*T, MIN*T + CW + T + 4);
    waitFor(1, n);
    checkRange("R7 ramp length", n, 7*T - 1, 7*T + 1);

    // R8: disable after done
    enable = 0; @(negedge clk);
    check("R8 code cleared", refCode, 0);
    check("R8 done dropped", done, 0);
    check("R8 ready kept", ready, 1);

    // R5: long delay honored; R7 small target spread by remainder
    cfgDelay = 25; cfgRamp = 20; targetCode = 3;
    repeat (3) @(negedge clk);
    expectCode(3);
    enable = 1;
    waitFor(0, n);
    checkRange("R5 long delay", n, 25*T, 25*T + CW + T + 4);
    waitFor(1, n);
    checkRange("R7 ramp length 20", n, 20*T - 1, 20*T + 1);

    // R9: zero ramp jumps to target after floor delay
    enable = 0; repeat (3) @(negedge clk);
    cfgDelay = 0; cfgRamp = 0; targetCode = 1023;
    expectCode(1023);
    enable = 1;
    waitFor(1, n);
    checkRange("R9 zero ramp at delay end", n, MIN*T, MIN*T + 3);

    // R8: abort mid-ramp then restart cleanly
    enable = 0; repeat (3) @(negedge clk);
    cfgDelay = 12; cfgRamp = 30; targetCode = 800;
    enable = 1;
    waitFor(0, n);
    repeat (40) @(negedge clk);
    check("R6 mid-ramp partial", int'(refCode > 0 && refCode < 800), 1);
    enable = 0; @(negedge clk);
    check("R8 abort clears code", refCode, 0);
    check("R8 abort drops ramping", ramping, 0);
    repeat (3) @(negedge clk);
    expectCode(800);
    enable = 1;
    waitFor(1, n);
    checkRange("R8 restart full run", n, 12*T + 30*T, 12*T + 30*T + CW + T + 6);

    check("R6 monotonic and bounded", int'(monoBad), 0);
    check("R7 all runs completed", expQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule